// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a free-running 16-bit time base with five event channels. A prescaler turns the bus clock into a one-cycle tick enable. The tick advances the counter by one every 1, 4, 8 or 16 bus cycles. Each channel holds a 16-bit target value. On the cycle the counter steps onto that value, the channel raises a status flag and can drive its output pin high or low, or flip it. A flag that software has enabled raises the interrupt line.

Two channels do more than the rest. Channel 0 is the master channel. When it hits its target, it can also force chosen levels onto the pins of channels 1 to 4, using a mask and a level register. Channel 4 can be switched into capture mode. In that mode a rising edge on the capture input copies the counter into the channel's register, and the channel stops producing compare events. Software talks to the block over a simple register port with a write strobe, a read strobe, an address and data. Read data is registered.

Top module: `compare_timer`

## Requirements
- R1: The counter (address 0) resets to 0 and increments by one per prescaler tick, wrapping at 16 bits. Writes to address 0 have no effect on it.
- R2: Control register (address 6) bits [1:0] select how many bus cycles pass between counter increments: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16.
- R3: Channel i (0 to 4) has a target register at address 1+i. On the clock edge where the counter becomes equal to that target, bit i of the flag register (address 8) is set.
- R4: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R5: The interrupt output goes high one cycle after any flag bit is set while the matching bit of the enable register (address 9) is 1. It is low when no enabled flag is set.
- R6: The action register (address 7) holds 2 bits per channel, at bits [2i+1:2i]. On a match the pin of channel i is left alone for 0, toggled for 1, cleared for 2 and set for 3. Pins of channels that did not match keep their level.
- R7: On a channel 0 match, each pin i from 1 to 4 whose bit i is set in the force mask (address 10) takes bit i of the force level register (address 11). Mask bit 0 has no effect.
- R8: When channel 0 and another channel match in the same cycle, the forced level wins on a masked pin. Unmasked channels still apply their own action.
- R9: With control bit 2 set, channel 4 is in capture mode. A rising edge of cap_in copies the counter into the channel 4 register (address 5) and sets flag 4. Counter matches on channel 4 then produce no flag and no pin change.
- R10: After reset all registers, pins and irq are 0. A read returns the addressed register on rd_data one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| cap_in | input | 1 | Capture input for channel 4 |
| pins | output | 5 | Channel output pins |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a match that lands exactly on a chosen counter value. The bench also has to show that the counter really sits at the target when the flag appears. To do this it runs the prescaler at divide-by-16, reads the counter, and programs a target a few ticks ahead. It then polls the flag register and reads the counter straight after, while the counter is still held on the target. The same-cycle case between the master channel and another channel is set up by writing identical targets into both channels within one tick window.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } pin_act_e;
endpackage

// File: rtl/cmpt_prescaler.sv
module cmpt_prescaler #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  // sel 0 -> every cycle, sel k>0 -> every 2^(k+1) cycles
  always_comb begin
    if (sel == '0) lim = '0;
    else           lim = DIV_W'((32'd1 << (32'(sel) + 32'd1)) - 32'd1);
  end

  assign tick = (div_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end

  // R2: a divided tick never repeats on the next cycle
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel
  import cmpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter bit CAN_CAPTURE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_now,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cap_mode,
  input  logic             cap_rise,
  input  pin_act_e         action,
  input  logic             force_en,
  input  logic             force_lvl,
  output logic [CNT_W-1:0] cmp_val,
  output logic             evt,
  output logic             pin
);
  logic [CNT_W-1:0] cmp_q;
  logic             pin_q, pin_d;
  logic             capture_on, match, cap_hit;

  assign capture_on = CAN_CAPTURE && cap_mode;
  assign match      = tick && !capture_on && (cnt_nxt == cmp_q);
  assign cap_hit    = capture_on && cap_rise;
  assign evt        = match || cap_hit;
  assign cmp_val    = cmp_q;
  assign pin        = pin_q;

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cap_hit) cmp_q <= cnt_now;
    else if (wr_cmp)  cmp_q <= wdata;
  end

  always_comb begin
    pin_d = pin_q;
    if (match) begin
      case (action)
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
    if (force_en) pin_d = force_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  // R6: set action drives the pin high when nothing overrides it
  a_r6_set_action: assert property (@(posedge clk) disable iff (rst)
    (match && !force_en && action == ACT_SET) |=> pin_q);
  // R6: toggle action inverts the pin
  a_r6_toggle_action: assert property (@(posedge clk) disable iff (rst)
    (match && !force_en && action == ACT_TOGGLE) |=> pin_q != $past(pin_q));
  // R8: forced level beats the channel's own action
  a_r8_force_wins: assert property (@(posedge clk) disable iff (rst)
    force_en |=> pin_q == $past(force_lvl));
  // R9: capture stores the counter value of the edge cycle
  a_r9_capture_load: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> cmp_q == $past(cnt_now));
endmodule

// File: rtl/compare_timer.sv
module compare_timer
  import cmpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 5,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic [NCH-1:0]    pins,
  output logic              irq
);
  localparam int A_CNT   = 0;
  localparam int A_CTRL  = NCH + 1;
  localparam int A_ACT   = NCH + 2;
  localparam int A_FLAG  = NCH + 3;
  localparam int A_IEN   = NCH + 4;
  localparam int A_FMASK = NCH + 5;
  localparam int A_FDATA = NCH + 6;
  localparam int CAP_CH  = NCH - 1;
  localparam int ACT_W   = 2 * NCH;
  localparam int CTRL_W  = SEL_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ACT_W-1:0]  act_q;
  logic [NCH-1:0]    flag_q, ien_q, fmask_q, fdata_q;
  logic [NCH-1:0]    evt, frc_en, clr;
  logic [CNT_W-1:0]  cmp_val [NCH];
  logic [CNT_W-1:0]  rd_q, rd_nxt;
  logic              irq_q, cap_q, cap_rise, tick;

  cmpt_prescaler #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .sel(ctrl_q[SEL_W-1:0]), .tick(tick)
  );

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign cap_rise = cap_in & ~cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_in;
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_master
      assign frc_en[g] = 1'b0;
    end else begin : g_slave
      assign frc_en[g] = evt[0] & fmask_q[g];
    end
    cmpt_channel #(.CNT_W(CNT_W), .CAN_CAPTURE(g == CAP_CH)) u_ch (
      .clk(clk), .rst(rst), .tick(tick),
      .cnt_now(cnt_q), .cnt_nxt(cnt_nxt),
      .wr_cmp(wr_en && addr == ADDR_W'(g + 1)),
      .wdata(wdata),
      .cap_mode(ctrl_q[SEL_W]), .cap_rise(cap_rise),
      .action(pin_act_e'(act_q[2*g +: 2])),
      .force_en(frc_en[g]), .force_lvl(fdata_q[g]),
      .cmp_val(cmp_val[g]), .evt(evt[g]), .pin(pins[g])
    );
  end

  assign clr = (wr_en && addr == ADDR_W'(A_FLAG)) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      act_q   <= '0;
      flag_q  <= '0;
      ien_q   <= '0;
      fmask_q <= '0;
      fdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_CTRL))  ctrl_q  <= wdata[CTRL_W-1:0];
      if (wr_en && addr == ADDR_W'(A_ACT))   act_q   <= wdata[ACT_W-1:0];
      if (wr_en && addr == ADDR_W'(A_IEN))   ien_q   <= wdata[NCH-1:0];
      if (wr_en && addr == ADDR_W'(A_FMASK)) fmask_q <= wdata[NCH-1:0];
      if (wr_en && addr == ADDR_W'(A_FDATA)) fdata_q <= wdata[NCH-1:0];
      flag_q <= (flag_q & ~clr) | evt;
      irq_q  <= |(flag_q & ien_q);
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == ADDR_W'(A_CNT)) rd_nxt = cnt_q;
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(i + 1)) rd_nxt = cmp_val[i];
    if (addr == ADDR_W'(A_CTRL))  rd_nxt = CNT_W'(ctrl_q);
    if (addr == ADDR_W'(A_ACT))   rd_nxt = CNT_W'(act_q);
    if (addr == ADDR_W'(A_FLAG))  rd_nxt = CNT_W'(flag_q);
    if (addr == ADDR_W'(A_IEN))   rd_nxt = CNT_W'(ien_q);
    if (addr == ADDR_W'(A_FMASK)) rd_nxt = CNT_W'(fmask_q);
    if (addr == ADDR_W'(A_FDATA)) rd_nxt = CNT_W'(fdata_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R1: counter moves by exactly one on a tick and holds otherwise
  a_r1_counter_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q == $past(cnt_nxt));
  a_r1_counter_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R5: interrupt only follows a cycle with some flag set
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|flag_q));
  for (genvar f = 0; f < NCH; f++) begin : g_flag_chk
    // R4: write-one clear takes effect when no event collides
    a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr[f] && !evt[f]) |=> !flag_q[f]);
    // R3 / R4: an event always leaves its flag set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt[f] |=> flag_q[f]);
  end
endmodule

// File: tb/test_compare_timer.sv
module test_compare_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CNT = 4'd0, A_CTRL = 4'd6, A_ACT = 4'd7, A_FLAG = 4'd8,
                         A_IEN = 4'd9, A_FMASK = 4'd10, A_FDATA = 4'd11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic [4:0]  pins;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  compare_timer i_compare_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .cap_in(cap_in), .pins(pins), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data; rd_en = 1'b0;
  endtask

  task automatic wait_flag(input int ch, output bit got);
    logic [15:0] v;
    got = 1'b0;
    for (int k = 0; k < 200; k++) begin
      rd(A_FLAG, v);
      if (v[ch]) begin got = 1'b1; break; end
    end
  endtask

  // arms channel ch at counter+3 and waits for its flag
  task automatic fire(input int ch, output logic [15:0] tgt, output bit got);
    logic [15:0] c;
    rd(A_CNT, c);
    tgt = c + 16'd3;
    wr(4'(ch + 1), tgt);
    wait_flag(ch, got);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c1, c2, tgt;
    logic [4:0]  prev;
    bit got;
    idle(5);
    rst = 1'b0;
    idle(2);

    // R10: reset state
    rd(A_CTRL, v);  chk(v == 0, "R10 ctrl reset", v, 0);
    rd(A_FLAG, v);  chk(v == 0, "R10 flag reset", v, 0);
    rd(A_ACT, v);   chk(v == 0, "R10 action reset", v, 0);
    chk(pins == 0, "R10 pins reset", pins, 0);
    chk(irq == 0, "R10 irq reset", irq, 0);

    // R2 / R1: counter rate for every prescale setting
    for (int s = 0; s < 4; s++) begin
      int dv;
      dv = (s == 0) ? 1 : (1 << (s + 1));
      wr(A_CTRL, 16'(s));
      idle(20);
      rd(A_CNT, c1);
      idle(63);
      rd(A_CNT, c2);
      chk(16'(c2 - c1) == 16'(64 / dv), "R2 counter rate", 16'(c2 - c1), 64 / dv);
    end

    // R1: write to counter ignored
    wr(A_CTRL, 16'd0);
    idle(5);
    rd(A_CNT, c1);
    wr(A_CNT, 16'hABCD);
    idle(5);
    rd(A_CNT, c2);
    chk(16'(c2 - c1) == 16'd7, "R1 counter write ignored", 16'(c2 - c1), 7);

    // R3 / R6: every channel with every pin action, divide by 16
    wr(A_CTRL, 16'd3);
    idle(20);
    for (int ch = 0; ch < 5; ch++) begin
      for (int a = 0; a < 4; a++) begin
        logic expd;
        wr(A_ACT, 16'(a << (2 * ch)));
        wr(A_FLAG, 16'h1F);
        rd(A_FLAG, v);
        chk(v == 0, "R4 flags cleared", v, 0);
        prev = pins;
        fire(ch, tgt, got);
        chk(got, "R3 flag on match", got, 1);
        rd(A_CNT, c1);
        chk(c1 == tgt, "R3 counter at target", c1, tgt);
        case (a)
          0: expd = prev[ch];
          1: expd = ~prev[ch];
          2: expd = 1'b0;
          default: expd = 1'b1;
        endcase
        chk(pins[ch] == expd, "R6 pin action", pins[ch], expd);
        chk((pins & ~(5'(1) << ch)) == (prev & ~(5'(1) << ch)),
            "R6 other pins hold", pins, prev);
      end
    end

    // R4: writing 0 keeps a flag; writing 1 clears it
    rd(A_FLAG, v);
    chk(v[4] == 1'b1, "R4 flag present", v[4], 1);
    wr(A_FLAG, 16'h0);
    rd(A_FLAG, v);
    chk(v[4] == 1'b1, "R4 zero write keeps flag", v[4], 1);
    wr(A_FLAG, 16'h10);
    rd(A_FLAG, v);
    chk(v[4] == 1'b0, "R4 one write clears flag", v[4], 0);

    // R5: interrupt gating
    wr(A_ACT, 16'h0);
    wr(A_FLAG, 16'h1F);
    wr(A_IEN, 16'h1);
    idle(2);
    chk(irq == 0, "R5 irq idle", irq, 0);
    fire(0, tgt, got);
    idle(2);
    chk(irq == 1, "R5 irq on enabled flag", irq, 1);
    wr(A_IEN, 16'h2);
    idle(2);
    chk(irq == 0, "R5 irq masked", irq, 0);
    wr(A_IEN, 16'h1);
    idle(2);
    chk(irq == 1, "R5 irq re-enabled", irq, 1);
    wr(A_FLAG, 16'h1);
    idle(2);
    chk(irq == 0, "R5 irq after clear", irq, 0);
    wr(A_IEN, 16'h0);

    // R7: master channel forces masked pins
    for (int t = 0; t < 4; t++) begin
      logic [4:0] m, d, e;
      case (t)
        0: begin m = 5'b11110; d = 5'b11110; end
        1: begin m = 5'b01010; d = 5'b00000; end
        2: begin m = 5'b10100; d = 5'b10101; end
        default: begin m = 5'b00111; d = 5'b11010; end
      endcase
      wr(A_FMASK, 16'(m));
      wr(A_FDATA, 16'(d));
      wr(A_FLAG, 16'h1F);
      prev = pins;
      fire(0, tgt, got);
      chk(got, "R7 master match", got, 1);
      for (int i = 0; i < 5; i++)
        e[i] = (i != 0 && m[i]) ? d[i] : prev[i];
      chk(pins == e, "R7 forced pins", pins, e);
    end

    // R8: same-cycle collision, force beats own action on masked pin
    wr(A_ACT, 16'(3 << 4) | 16'(3 << 6));
    wr(A_FMASK, 16'h04);
    wr(A_FDATA, 16'h00);
    wr(A_FLAG, 16'h1F);
    rd(A_CNT, c1);
    tgt = c1 + 16'd4;
    wr(4'd1, tgt);
    wr(4'd3, tgt);
    wr(4'd4, tgt);
    wait_flag(0, got);
    rd(A_FLAG, v);
    chk(v[3:2] == 2'b11 && v[0], "R8 both matched", v, 16'h0D);
    chk(pins[2] == 1'b0, "R8 force wins", pins[2], 0);
    chk(pins[3] == 1'b1, "R8 unmasked own action", pins[3], 1);
    wr(A_FMASK, 16'h0);

    // R9: capture mode on channel 4
    wr(A_ACT, 16'(1 << 8));
    wr(A_CTRL, 16'h7);
    wr(A_FLAG, 16'h1F);
    rd(A_CNT, c1);
    cap_in = 1'b1;
    idle(2);
    cap_in = 1'b0;
    rd(A_CNT, c2);
    rd(4'd5, v);
    chk(v >= c1 && v <= c2, "R9 captured value", v, c1);
    rd(A_FLAG, v);
    chk(v[4] == 1'b1, "R9 capture flag", v[4], 1);
    wr(A_FLAG, 16'h1F);
    prev = pins;
    rd(A_CNT, c1);
    wr(4'd5, c1 + 16'd2);
    idle(80);
    rd(A_FLAG, v);
    chk(v[4] == 1'b0, "R9 no compare in capture", v[4], 0);
    chk(pins[4] == prev[4], "R9 pin untouched in capture", pins[4], prev[4]);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule